// File: doc/BRIEF.md
# Multicycle 16-bit Load/Store Processor Core

This block is a small processor core that executes a 16-bit load/store instruction subset. A control state machine steps each instruction through up to six phases: fetch, decode, address evaluation, operand fetch, execute and store. Each phase takes one or more clock cycles. The datapath holds eight 16-bit general registers, a program counter, an instruction register, a memory address register and a memory data register. Every memory access goes through the address and data registers. The memory is an external synchronous single-port word memory.

The supported operations are:
- register-to-register add, bitwise AND and bitwise NOT;
- a load whose address is a base register plus a signed offset;
- an unconditional jump through a register;
- a branch that compares a stored sign condition with a mask taken from the instruction.

An enable input pauses the core. While enable is low, every register holds its value and the core issues no memory reads.

Top module: `mc16_core`

## Requirements
- R1: Reset state.
  - Reset clears all eight registers and the address register, sets the program counter to 0x3000 and sets the condition to zero.
  - No read is issued during reset.
  - The first read after reset is at address 0x3000.
- R2: Instruction fetch.
  - Each fetch places the PC in the address register and then asserts `memRead`.
  - The word returned on `memRdata` in the cycle after the strobe is captured, then copied into the instruction register.
  - The PC is then incremented by one, so straight-line code is fetched at consecutive addresses.
- R3: Opcode 0001 adds.
  - The register selected by bits [8:6] is added to the register selected by bits [2:0], modulo 2^16.
  - The sum is written to the register selected by bits [11:9]. Bits [5:3] are ignored.
- R4: Opcode 0101 uses the same field layout as R3 and writes the bitwise AND of the two sources.
- R5: Opcode 1001, with bits [5:0] all ones, writes the bitwise complement of the register selected by bits [8:6] into the register selected by bits [11:9].
- R6: Opcode 0110 loads a word from memory.
  - The read address is the register selected by bits [8:6] plus bits [5:0], sign-extended.
  - The word read is written to the register selected by bits [11:9].
- R7: Condition code.
  - Every register write sets the condition to exactly one of negative (bit 15 set), zero, or positive, according to the value written.
  - This applies to arithmetic and load writes alike.
- R8: Opcode 0000 is a branch.
  - Bit 11 tests negative, bit 10 tests zero and bit 9 tests positive.
  - The branch is taken when any set bit matches the current condition.
  - When taken, the target is the incremented PC plus bits [8:0], sign-extended. Otherwise execution falls through.
- R9: Opcode 1100 copies the register selected by bits [8:6] into the PC unconditionally.
- R10: Every other opcode only fetches. It leaves the registers and the condition unchanged, and the next fetch is at PC+1.
- R11: While `clkEn` is low, no state changes and `memRead` stays low. A run with enable toggled at arbitrary cycles produces the same read address sequence as an unstalled run.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Active-low synchronous reset |
| clkEn | input | 1 | Progress enable; low freezes the core |
| memAddr | output | 16 | Word address, driven from the address register |
| memRead | output | 1 | Read strobe; memory returns data on the next cycle |
| memRdata | input | 16 | Read data from the synchronous memory |

## Verification
The assertions rely on two assumptions about the memory:
- It returns a valid word on `memRdata` in the cycle after every `memRead` strobe.
- It holds that word until the next strobe.

The bench's memory model keeps to both: it captures only when the strobe is high.

The assertions also take the instruction stream to be arbitrary. Register and condition state are observed indirectly, through load addresses, jump targets and branch outcomes. Enable is toggled only at falling edges, so the core sees a clean enable at each rising edge.

// File: rtl/mc16_pkg.sv
package mc16_pkg;
  localparam int WORD_W   = 16;
  localparam int REG_AW   = 3;
  localparam int NUM_REGS = 1 << REG_AW;
  localparam int OPC_W    = 4;
  localparam int NUM_OPC  = 1 << OPC_W;

  localparam logic [OPC_W-1:0] OPC_BR  = 4'b0000;
  localparam logic [OPC_W-1:0] OPC_ADD = 4'b0001;
  localparam logic [OPC_W-1:0] OPC_AND = 4'b0101;
  localparam logic [OPC_W-1:0] OPC_LDR = 4'b0110;
  localparam logic [OPC_W-1:0] OPC_NOT = 4'b1001;
  localparam logic [OPC_W-1:0] OPC_JMP = 4'b1100;

  typedef enum logic [3:0] {
    PH_F_MAR, PH_F_RD, PH_F_MDR, PH_F_IR, PH_DECODE,
    PH_EVAL, PH_OP_RD, PH_OP_MDR, PH_EXEC, PH_STORE
  } phaseT;

  typedef struct packed {
    logic ldMarPc;
    logic ldMarEa;
    logic memRd;
    logic ldMdr;
    logic ldIrIncPc;
    logic ldAlu;
    logic ldTgt;
    logic wrRegAlu;
    logic wrRegMdr;
    logic pcJmp;
    logic pcBr;
  } ctrlT;
endpackage

// File: rtl/mc16_regfile.sv
module mc16_regfile #(
  parameter int W  = 16,
  parameter int AW = 3
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic          we,
  input  logic [AW-1:0] wAddr,
  input  logic [W-1:0]  wData,
  input  logic [AW-1:0] rAddrA,
  output logic [W-1:0]  rDataA,
  input  logic [AW-1:0] rAddrB,
  output logic [W-1:0]  rDataB
);
  localparam int N = 1 << AW;

  logic [W-1:0] regs [N];

  for (genvar i = 0; i < N; i++) begin : g_entry
    always_ff @(posedge clk) begin
      if (!rstN)                                    regs[i] <= '0;
      else if (we && (wAddr == AW'(i)))             regs[i] <= wData;
    end
  end

  assign rDataA = regs[rAddrA];
  assign rDataB = regs[rAddrB];
endmodule

// File: rtl/mc16_datapath.sv
module mc16_datapath
  import mc16_pkg::*;
#(
  parameter logic [WORD_W-1:0] RESET_PC = 16'h3000
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 en,
  input  ctrlT                 ctrl,
  input  logic [WORD_W-1:0]    memRdata,
  output logic [WORD_W-1:0]    memAddr,
  output logic [NUM_OPC-1:0]   opHot
);
  logic [WORD_W-1:0] pc, ir, mar, mdr, aluQ;
  logic [2:0]        cc;           // {n, z, p}
  logic [WORD_W-1:0] srcA, srcB, wData, aluNext, sext6, sext9;
  logic              regWe, taken;

  assign sext6 = {{(WORD_W-6){ir[5]}}, ir[5:0]};
  assign sext9 = {{(WORD_W-9){ir[8]}}, ir[8:0]};
  assign opHot = NUM_OPC'(1) << ir[WORD_W-1 -: OPC_W];

  mc16_regfile #(.W(WORD_W), .AW(REG_AW)) u_rf (
    .clk(clk), .rstN(rstN), .we(regWe), .wAddr(ir[11:9]), .wData(wData),
    .rAddrA(ir[8:6]), .rDataA(srcA), .rAddrB(ir[2:0]), .rDataB(srcB)
  );

  assign regWe = en && (ctrl.wrRegAlu || ctrl.wrRegMdr);
  assign wData = ctrl.wrRegMdr ? mdr : aluQ;
  assign taken = |(ir[11:9] & cc);

  always_comb begin
    unique case (ir[WORD_W-1 -: OPC_W])
      OPC_AND: aluNext = srcA & srcB;
      OPC_NOT: aluNext = ~srcA;
      default: aluNext = srcA + srcB;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      pc   <= RESET_PC;
      ir   <= '0;
      mar  <= '0;
      mdr  <= '0;
      aluQ <= '0;
      cc   <= 3'b010;
    end else if (en) begin
      if (ctrl.ldMarPc)      mar <= pc;
      else if (ctrl.ldMarEa) mar <= srcA + sext6;
      if (ctrl.ldMdr)        mdr <= memRdata;
      if (ctrl.ldIrIncPc) begin
        ir <= mdr;
        pc <= pc + 1'b1;
      end else if (ctrl.pcJmp) begin
        pc <= srcA;
      end else if (ctrl.pcBr && taken) begin
        pc <= aluQ;
      end
      if (ctrl.ldAlu)        aluQ <= aluNext;
      else if (ctrl.ldTgt)   aluQ <= pc + sext9;
      if (regWe)             cc <= {wData[WORD_W-1], wData == '0,
                                    !wData[WORD_W-1] && (wData != '0)};
    end
  end

  assign memAddr = mar;

  // R7
  cc_single_flag_chk: assert property (@(posedge clk) disable iff (!rstN)
    $countones(cc) == 1);

  // R7
  cc_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    !regWe |=> $stable(cc));

  // R2
  pc_step_chk: assert property (@(posedge clk) disable iff (!rstN)
    (en && ctrl.ldIrIncPc) |=> pc == $past(pc) + 16'd1);

  // R10
  ir_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    !(en && ctrl.ldIrIncPc) |=> $stable(ir));
endmodule

// File: rtl/mc16_control.sv
module mc16_control
  import mc16_pkg::*;
(
  input  logic               clk,
  input  logic               rstN,
  input  logic               en,
  input  logic [NUM_OPC-1:0] opHot,
  output ctrlT               ctrl
);
  localparam logic [NUM_OPC-1:0] KNOWN =
    (NUM_OPC'(1) << OPC_BR)  | (NUM_OPC'(1) << OPC_ADD) | (NUM_OPC'(1) << OPC_AND) |
    (NUM_OPC'(1) << OPC_LDR) | (NUM_OPC'(1) << OPC_NOT) | (NUM_OPC'(1) << OPC_JMP);

  phaseT state, nextState;
  logic  isAlu, isLdr, isBr, isJmp, isNop;

  assign isAlu = opHot[OPC_ADD] | opHot[OPC_AND] | opHot[OPC_NOT];
  assign isLdr = opHot[OPC_LDR];
  assign isBr  = opHot[OPC_BR];
  assign isJmp = opHot[OPC_JMP];
  assign isNop = |(opHot & ~KNOWN);

  always_comb begin
    nextState = state;
    unique case (state)
      PH_F_MAR:  nextState = PH_F_RD;
      PH_F_RD:   nextState = PH_F_MDR;
      PH_F_MDR:  nextState = PH_F_IR;
      PH_F_IR:   nextState = PH_DECODE;
      PH_DECODE: begin
        if (isNop)                nextState = PH_F_MAR;
        else if (isAlu)           nextState = PH_EXEC;
        else if (isLdr || isBr)   nextState = PH_EVAL;
        else if (isJmp)           nextState = PH_STORE;
        else                      nextState = PH_F_MAR;
      end
      PH_EVAL:   nextState = isLdr ? PH_OP_RD : PH_STORE;
      PH_OP_RD:  nextState = PH_OP_MDR;
      PH_OP_MDR: nextState = PH_STORE;
      PH_EXEC:   nextState = PH_STORE;
      PH_STORE:  nextState = PH_F_MAR;
      default:   nextState = PH_F_MAR;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN)   state <= PH_F_MAR;
    else if (en) state <= nextState;
  end

  always_comb begin
    ctrl           = '0;
    ctrl.ldMarPc   = (state == PH_F_MAR);
    ctrl.memRd     = (state == PH_F_RD) || (state == PH_OP_RD);
    ctrl.ldMdr     = (state == PH_F_MDR) || (state == PH_OP_MDR);
    ctrl.ldIrIncPc = (state == PH_F_IR);
    ctrl.ldMarEa   = (state == PH_EVAL) && isLdr;
    ctrl.ldTgt     = (state == PH_EVAL) && isBr;
    ctrl.ldAlu     = (state == PH_EXEC);
    ctrl.wrRegAlu  = (state == PH_STORE) && isAlu;
    ctrl.wrRegMdr  = (state == PH_STORE) && isLdr;
    ctrl.pcJmp     = (state == PH_STORE) && isJmp;
    ctrl.pcBr      = (state == PH_STORE) && isBr;
  end

  // R11
  stall_freeze_chk: assert property (@(posedge clk) disable iff (!rstN)
    !en |=> $stable(state));

  // R2
  read_then_capture_chk: assert property (@(posedge clk) disable iff (!rstN)
    (en && ctrl.memRd) |=> ctrl.ldMdr);

  // R10
  one_writer_chk: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({ctrl.ldIrIncPc, ctrl.wrRegAlu, ctrl.wrRegMdr, ctrl.pcJmp, ctrl.pcBr}));
endmodule

// File: rtl/mc16_core.sv
module mc16_core
  import mc16_pkg::*;
#(
  parameter logic [15:0] RESET_PC = 16'h3000
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        clkEn,
  output logic [15:0] memAddr,
  output logic        memRead,
  input  logic [15:0] memRdata
);
  ctrlT               ctrl;
  logic [NUM_OPC-1:0] opHot;

  mc16_control u_ctrl (
    .clk(clk), .rstN(rstN), .en(clkEn), .opHot(opHot), .ctrl(ctrl)
  );

  mc16_datapath #(.RESET_PC(RESET_PC)) u_dp (
    .clk(clk), .rstN(rstN), .en(clkEn), .ctrl(ctrl),
    .memRdata(memRdata), .memAddr(memAddr), .opHot(opHot)
  );

  assign memRead = ctrl.memRd && clkEn && rstN;

  // R11
  no_read_stalled_chk: assert property (@(posedge clk) disable iff (!rstN)
    !clkEn |-> !memRead);
endmodule

// File: tb/mc16_core_tb.sv
module mc16_core_tb;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        clkEn = 1'b0;
  logic [15:0] memAddr, memRdata;
  logic        memRead;

  logic [15:0] mem [0:255];
  logic [15:0] rdLog [0:15];
  int          rdCnt;
  int          nChecks = 0;
  int          nFails = 0;
  int          cycles = 0;
  bit          stallMode = 1'b0;

  always #10 clk = ~clk;

  mc16_core u_dut (
    .clk(clk), .rstN(rstN), .clkEn(clkEn),
    .memAddr(memAddr), .memRead(memRead), .memRdata(memRdata)
  );

  always @(posedge clk) begin
    cycles <= cycles + 1;
    if (memRead) memRdata <= mem[memAddr[7:0]];
  end

  initial begin
    wait (cycles >= 190000);
    nFails++;
    $display("FAIL watchdog: act %0d cycles exp < 190000", cycles);
    $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
    $finish;
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    nChecks++;
    if (!ok) begin
      nFails++;
      $display("FAIL %s: act 0x%0h exp 0x%0h", req, act, exp);
    end
  endtask

  function automatic logic [15:0] encLdr(input int d, input int b, input int off);
    return {4'b0110, 3'(d), 3'(b), 6'(off)};
  endfunction
  function automatic logic [15:0] encBr(input int mask, input int off);
    return {4'b0000, 3'(mask), 9'(off)};
  endfunction
  function automatic logic [2:0] flagOf(input logic [15:0] v);
    if (v[15])       return 3'b100;
    else if (v == 0) return 3'b010;
    else             return 3'b001;
  endfunction

  task automatic clearMem();
    for (int i = 0; i < 256; i++) mem[i] = 16'h0000;
  endtask

  task automatic resetCore();
    @(negedge clk);
    rstN = 1'b0; clkEn = 1'b0;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    rdCnt = 0;
  endtask

  task automatic runReads(input int need, input string req);
    int guard = 0;
    clkEn = stallMode ? 1'($urandom % 2) : 1'b1;
    while (rdCnt < need && guard < 2000) begin
      @(negedge clk);
      if (memRead && rdCnt < 16) begin
        rdLog[rdCnt] = memAddr;
        rdCnt++;
      end
      clkEn = stallMode ? 1'($urandom % 2) : 1'b1;
      guard++;
    end
    if (rdCnt < need) chk(1'b0, req, rdCnt, need);
    clkEn = 1'b0;
  endtask

  localparam logic [15:0] VALS [8] = '{16'h0000, 16'h0001, 16'h7FFF, 16'h8000,
                                       16'hFFFF, 16'h1234, 16'h00FF, 16'hAAAA};

  task automatic opSweep();
    for (int op = 0; op < 3; op++) begin
      for (int ia = 0; ia < 8; ia++) begin
        for (int ib = 0; ib < 8; ib++) begin
          logic [15:0] a, b, res;
          int mask, nx;
          bit tk;
          string rq;
          a = VALS[ia]; b = VALS[ib];
          mask = ((ia * 8 + ib + op) % 7) + 1;
          clearMem();
          mem[16] = a; mem[17] = b;
          mem[0] = encLdr(1, 0, 16);
          mem[1] = encLdr(2, 0, 17);
          case (op)
            0: begin mem[2] = {4'b0001, 3'd3, 3'd1, 3'b101, 3'd2}; res = a + b; rq = "R3"; end
            1: begin mem[2] = {4'b0101, 3'd3, 3'd1, 3'b000, 3'd2}; res = a & b; rq = "R4"; end
            default: begin mem[2] = {4'b1001, 3'd3, 3'd1, 6'b111111}; res = ~a; rq = "R5"; end
          endcase
          mem[3] = encBr(mask, 1);
          mem[4] = encLdr(5, 0, 20);
          mem[5] = encLdr(4, 3, 0);
          mem[6] = encBr(7, -7);
          tk = |(3'(mask) & flagOf(res));
          resetCore();
          runReads(10, "R2 run");
          // R2 and R6: fetch order and load addresses
          chk(rdLog[0] == 16'h3000 && rdLog[1] == 16'h0010 && rdLog[2] == 16'h3001 &&
              rdLog[3] == 16'h0011 && rdLog[4] == 16'h3002 && rdLog[5] == 16'h3003,
              stallMode ? "R11 R2 prefix" : "R2 R6 prefix", rdLog[5], 16'h3003);
          // R8 and R7: branch outcome follows condition of the written result
          chk(rdLog[6] == (tk ? 16'h3005 : 16'h3004),
              stallMode ? "R11 R8" : "R8 R7 branch", rdLog[6], tk ? 16'h3005 : 16'h3004);
          nx = tk ? 7 : 9;
          chk(rdLog[nx] == res, stallMode ? "R11 result" : rq, rdLog[nx], res);
        end
      end
    end
  endtask

  initial begin
    // R1: reset state visible at the ports
    clearMem();
    mem[0] = encBr(3'b010, 1);
    mem[2] = encBr(3'b101, 1);
    resetCore();
    rstN = 1'b0;
    @(negedge clk);
    chk(memRead == 1'b0 && memAddr == 16'h0000, "R1 reset ports", memAddr, 0);
    rstN = 1'b1;
    rdCnt = 0;
    // R11: enable low after reset gives no reads
    for (int i = 0; i < 12; i++) begin
      @(negedge clk);
      if (memRead) rdCnt++;
    end
    chk(rdCnt == 0, "R11 held", rdCnt, 0);
    runReads(3, "R1 run");
    chk(rdLog[0] == 16'h3000, "R1 first fetch", rdLog[0], 16'h3000);
    chk(rdLog[1] == 16'h3002, "R1 zero cc taken", rdLog[1], 16'h3002);
    chk(rdLog[2] == 16'h3003, "R8 not taken", rdLog[2], 16'h3003);

    // R6 and R7: condition from loaded value, all masks
    for (int iv = 0; iv < 8; iv++) begin
      for (int m = 1; m < 8; m++) begin
        bit tk;
        clearMem();
        mem[16] = VALS[iv];
        mem[0] = encLdr(1, 0, 16);
        mem[1] = encBr(m, 1);
        tk = |(3'(m) & flagOf(VALS[iv]));
        resetCore();
        runReads(4, "R7 run");
        chk(rdLog[1] == 16'h0010, "R6 load addr", rdLog[1], 16'h0010);
        chk(rdLog[3] == (tk ? 16'h3003 : 16'h3002), "R7 load cc", rdLog[3],
            tk ? 16'h3003 : 16'h3002);
      end
    end

    // R9, R10, R8 backward, R6 negative offset: every unsupported opcode
    for (int op = 0; op < 16; op++) begin
      if (op inside {0, 1, 5, 6, 9, 12}) continue;
      clearMem();
      mem[16] = 16'h3008;
      mem[0] = encLdr(1, 0, 16);
      mem[1] = {4'b1100, 3'd0, 3'd1, 6'd0};
      mem[8] = encBr(7, -5);
      mem[4] = {4'(op), 12'hFFF};
      mem[5] = encBr(3'b001, 1);
      mem[7] = encLdr(2, 1, -8);
      resetCore();
      runReads(8, "R9 run");
      chk(rdLog[3] == 16'h3008, "R9 jump", rdLog[3], 16'h3008);
      chk(rdLog[4] == 16'h3004, "R8 backward", rdLog[4], 16'h3004);
      chk(rdLog[5] == 16'h3005, "R10 next fetch", rdLog[5], 16'h3005);
      chk(rdLog[6] == 16'h3007, "R10 cc kept", rdLog[6], 16'h3007);
      chk(rdLog[7] == 16'h3000, "R10 reg kept", rdLog[7], 16'h3000);
    end

    opSweep();
    stallMode = 1'b1;
    opSweep();
    stallMode = 1'b0;

    $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
    $finish;
  end
endmodule